// File: doc/BRIEF.md
# Level-Masked Interrupt Acceptance Controller

This block gathers interrupt requests from a set of peripheral sources and decides when the processor takes one. Every source owns a sticky cause bit, set by a peripheral event and cleared only by an explicit write-one-to-clear from software. It also owns an enable bit and a programmable 3-bit priority level. Sources whose cause and enable are both set, and whose level is not the disabled code, compete in a priority selector. The selector presents the winning level and source index to an acceptance stage.

The acceptance stage keeps a current-level mask. A selected request is taken only if its level outranks the mask, the global interrupt-enable input is high, and the processor signals an instruction boundary in that same cycle. On acceptance the mask is raised to the accepted level and the previous mask is pushed onto a small save stack. The stage also emits a one-cycle acknowledge carrying the source index. A return strobe pops the stack and restores the mask that was in force before the handler began, so nested handlers unwind in order.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A cause bit is set in the cycle after its event input is high and stays set until a clear bit for that source is written as 1. When event and clear for the same source are high in the same cycle, the cause ends up set.
- R2: A source competes only when its cause bit is 1, its enable bit is 1 and its level is not 7. Level code 7 means disabled.
- R3: Among competing sources, the numerically lowest level wins, because a lower value means higher priority. On equal levels the lower source index wins. `req_any_o`, `req_lvl_o` and `req_src_o` show the current winner without a clock delay from the registered state.
- R4: A winner is a candidate only when its level is strictly lower in value than the mask. An equal or lower-priority level is never accepted.
- R5: A candidate is accepted only in a cycle where `gie_i` and `boundary_i` are both 1 and `reti_i` is 0. Otherwise nothing is accepted and the request stays pending.
- R6: After an acceptance, in the following cycle `ack_o` is 1 for that single cycle, `ack_src_o` holds the winning index, and `mask_o` equals the accepted level.
- R7: Acceptance does not clear the accepted source's cause bit.
- R8: `reti_i` restores the mask saved at the most recent acceptance that has not yet returned. Returns unwind nested acceptances in reverse order. A return with no outstanding acceptance leaves the mask unchanged.
- R9: After reset the mask is 7, all causes and enables are 0, all levels are 7 and `ack_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NSRC | Peripheral events, one per source |
| clr_i | input | NSRC | Write-one-to-clear of cause bits |
| en_wr_i | input | 1 | Load the enable vector |
| en_wdata_i | input | NSRC | New enable vector |
| lvl_wr_i | input | 1 | Write one source's level |
| lvl_idx_i | input | $clog2(NSRC) | Source index for the level write |
| lvl_wdata_i | input | LW | Level value to write |
| gie_i | input | 1 | Global interrupt enable |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-handler strobe |
| cause_o | output | NSRC | Cause bits |
| req_any_o | output | 1 | Some source is competing |
| req_lvl_o | output | LW | Level of the current winner |
| req_src_o | output | $clog2(NSRC) | Index of the current winner |
| ack_o | output | 1 | One-cycle acceptance pulse |
| ack_src_o | output | $clog2(NSRC) | Index of the accepted source |
| mask_o | output | LW | Current level mask |

## Verification
The bench builds the block with its default parameters: eight sources and 3-bit levels. This gives seven usable priority levels and a save stack seven entries deep. With these values every level code, the disabled code 7, equal-level ties between sources, and nesting of handlers all the way from mask 7 down to mask 0 come within reach. A behavioural reference model compares every output on every clock. It does so through a directed sequence and then through a long randomized run that mixes returns, level rewrites and withheld boundary or enable cycles.

// File: rtl/lvl_irq_pkg.sv
// Package: shared defaults and the acceptance-stage action encoding.
// Assumes: nothing beyond IEEE 1800-2017.
package lvl_irq_pkg;
    localparam int DEF_NSRC = 8;
    localparam int DEF_LW   = 3;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_TAKE = 2'd1,
        ACT_RET  = 2'd2
    } acc_act_e;
endpackage

// File: rtl/irq_src_bank.sv
// Per-source state: sticky cause, enable and programmed level.
// Assumes: level value all-ones means disabled; an event wins over a clear
// in the same cycle so that no event is lost.
module irq_src_bank #(
    parameter int NSRC = 8,
    parameter int LW   = 3,
    parameter int SW   = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    evt_i,
    input  logic [NSRC-1:0]    clr_i,
    input  logic               en_wr_i,
    input  logic [NSRC-1:0]    en_wdata_i,
    input  logic               lvl_wr_i,
    input  logic [SW-1:0]      lvl_idx_i,
    input  logic [LW-1:0]      lvl_wdata_i,
    output logic [NSRC-1:0]    cause_o,
    output logic [NSRC-1:0]    pend_o,
    output logic [NSRC*LW-1:0] lvl_flat_o
);
    localparam logic [LW-1:0] LVL_OFF = '1;

    logic [NSRC-1:0] en_q;

    // Enable vector register, loaded as a whole.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_wdata_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic          cause_q;
        logic [LW-1:0] lvl_q;

        // Sticky cause bit: set by an event, dropped only by a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) cause_q <= 1'b0;
            else        cause_q <= evt_i[g] | (cause_q & ~clr_i[g]);
        end

        // Programmed priority level for this source.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  lvl_q <= LVL_OFF;
            else if (lvl_wr_i && lvl_idx_i == SW'(g))    lvl_q <= lvl_wdata_i;
        end

        assign cause_o[g]               = cause_q;
        assign pend_o[g]                = cause_q & en_q[g] & (lvl_q != LVL_OFF);
        assign lvl_flat_o[g*LW +: LW]   = lvl_q;
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Priority selector: picks the competing source with the lowest level value,
// lowest index on ties.
// Assumes: every competing source has a level below all-ones.
module irq_prio_sel #(
    parameter int NSRC = 8,
    parameter int LW   = 3,
    parameter int SW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]    pend_i,
    input  logic [NSRC*LW-1:0] lvl_flat_i,
    output logic               any_o,
    output logic [LW-1:0]      lvl_o,
    output logic [SW-1:0]      idx_o
);
    // Linear scan; a strict compare keeps the earliest index on ties.
    always_comb begin
        any_o = 1'b0;
        lvl_o = '1;
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (lvl_flat_i[i*LW +: LW] < lvl_o)) begin
                any_o = 1'b1;
                lvl_o = lvl_flat_i[i*LW +: LW];
                idx_o = SW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_accept.sv
// Acceptance stage: level mask, save stack and acknowledge pulse.
// Assumes: each acceptance strictly lowers the mask value, so the stack
// never holds more than 2**LW-1 entries; a return blocks acceptance.
module irq_accept #(
    parameter int LW = 3,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_i,
    input  logic [LW-1:0] lvl_i,
    input  logic [SW-1:0] idx_i,
    input  logic          gie_i,
    input  logic          boundary_i,
    input  logic          reti_i,
    output logic          ack_o,
    output logic [SW-1:0] ack_src_o,
    output logic [LW-1:0] mask_o
);
    import lvl_irq_pkg::*;

    localparam int STK_D = (1 << LW) - 1;
    localparam int SPW   = $clog2(STK_D + 1);
    localparam int STK_N = 1 << SPW;

    logic [LW-1:0]  mask_q;
    logic [LW-1:0]  stk_q [STK_N];
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] sp_m1;
    acc_act_e       act;

    assign sp_m1 = sp_q - SPW'(1);

    // Decide this cycle's action: return first, then a qualified take.
    always_comb begin
        act = ACT_NONE;
        if (reti_i) begin
            if (sp_q != '0) act = ACT_RET;
        end else if (any_i && (lvl_i < mask_q) && gie_i && boundary_i
                     && (sp_q != SPW'(STK_D))) begin
            act = ACT_TAKE;
        end
    end

    // Mask and stack pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            sp_q   <= '0;
        end else begin
            case (act)
                ACT_TAKE: begin
                    mask_q <= lvl_i;
                    sp_q   <= sp_q + SPW'(1);
                end
                ACT_RET: begin
                    mask_q <= stk_q[sp_m1];
                    sp_q   <= sp_m1;
                end
                default: ;
            endcase
        end
    end

    // Save stack storage, written on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STK_N; k++) stk_q[k] <= '1;
        end else if (act == ACT_TAKE) begin
            stk_q[sp_q] <= mask_q;
        end
    end

    // Acknowledge pulse with the accepted index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o     <= 1'b0;
            ack_src_o <= '0;
        end else begin
            ack_o <= (act == ACT_TAKE);
            if (act == ACT_TAKE) ack_src_o <= idx_i;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Top: level-masked interrupt acceptance controller. Wires the source bank,
// the priority selector and the acceptance stage.
// Assumes: synchronous active-low reset; all strobes are one clock wide.
module lvl_irq_ctrl #(
    parameter int NSRC = lvl_irq_pkg::DEF_NSRC,
    parameter int LW   = lvl_irq_pkg::DEF_LW,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic            lvl_wr_i,
    input  logic [SW-1:0]   lvl_idx_i,
    input  logic [LW-1:0]   lvl_wdata_i,
    input  logic            gie_i,
    input  logic            boundary_i,
    input  logic            reti_i,
    output logic [NSRC-1:0] cause_o,
    output logic            req_any_o,
    output logic [LW-1:0]   req_lvl_o,
    output logic [SW-1:0]   req_src_o,
    output logic            ack_o,
    output logic [SW-1:0]   ack_src_o,
    output logic [LW-1:0]   mask_o
);
    logic [NSRC-1:0]    pend;
    logic [NSRC*LW-1:0] lvl_flat;

    irq_src_bank #(.NSRC(NSRC), .LW(LW), .SW(SW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .clr_i       (clr_i),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .lvl_wr_i    (lvl_wr_i),
        .lvl_idx_i   (lvl_idx_i),
        .lvl_wdata_i (lvl_wdata_i),
        .cause_o     (cause_o),
        .pend_o      (pend),
        .lvl_flat_o  (lvl_flat)
    );

    irq_prio_sel #(.NSRC(NSRC), .LW(LW), .SW(SW)) u_sel (
        .pend_i     (pend),
        .lvl_flat_i (lvl_flat),
        .any_o      (req_any_o),
        .lvl_o      (req_lvl_o),
        .idx_o      (req_src_o)
    );

    irq_accept #(.LW(LW), .SW(SW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_i      (req_any_o),
        .lvl_i      (req_lvl_o),
        .idx_i      (req_src_o),
        .gie_i      (gie_i),
        .boundary_i (boundary_i),
        .reti_i     (reti_i),
        .ack_o      (ack_o),
        .ack_src_o  (ack_src_o),
        .mask_o     (mask_o)
    );
endmodule

// File: rtl/lvl_irq_chk.sv
// Checker: temporal properties of the controller's ports, bound to the top.
// Assumes: reset is held for at least one clock at start.
module lvl_irq_chk #(
    parameter int NSRC = 8,
    parameter int LW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] clr_i,
    input logic            gie_i,
    input logic            boundary_i,
    input logic            reti_i,
    input logic [NSRC-1:0] cause_o,
    input logic            req_any_o,
    input logic [LW-1:0]   req_lvl_o,
    input logic            ack_o,
    input logic [LW-1:0]   mask_o
);
    // R7
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_o) & ~$past(clr_i) & ~cause_o) == '0));

    // R4
    take_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(req_any_o) && ($past(req_lvl_o) < $past(mask_o))));

    // R5
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !ack_o);

    // R5
    boundary_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary_i || reti_i) |=> !ack_o);

    // R6
    mask_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (mask_o == $past(req_lvl_o)));

    // R8
    mask_rise_on_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o > $past(mask_o)) |-> $past(reti_i));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reti_i && !(gie_i && boundary_i)) |=> $stable(mask_o));
endmodule

bind lvl_irq_ctrl lvl_irq_chk #(.NSRC(NSRC), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .gie_i      (gie_i),
    .boundary_i (boundary_i),
    .reti_i     (reti_i),
    .cause_o    (cause_o),
    .req_any_o  (req_any_o),
    .req_lvl_o  (req_lvl_o),
    .ack_o      (ack_o),
    .mask_o     (mask_o)
);

// File: tb/tb_lvl_irq_ctrl.sv
// Bench: directed sequence plus randomized run against a behavioural model.
module tb_lvl_irq_ctrl;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = '0, clr = '0, en_wdata = '0;
    logic       en_wr = 1'b0, lvl_wr = 1'b0;
    logic [2:0] lvl_idx = '0, lvl_wdata = '0;
    logic       gie = 1'b0, bnd = 1'b0, reti = 1'b0;
    logic [7:0] cause;
    logic       req_any, ack;
    logic [2:0] req_lvl, req_src, ack_src, mask;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lvl_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .lvl_wr_i(lvl_wr),
        .lvl_idx_i(lvl_idx), .lvl_wdata_i(lvl_wdata), .gie_i(gie),
        .boundary_i(bnd), .reti_i(reti), .cause_o(cause),
        .req_any_o(req_any), .req_lvl_o(req_lvl), .req_src_o(req_src),
        .ack_o(ack), .ack_src_o(ack_src), .mask_o(mask)
    );

    // Behavioural reference model.
    int m_cause [N];
    int m_en    [N];
    int m_lvl   [N];
    int m_mask, m_ack, m_src;
    int m_stack [$];

    function automatic void msel(output int a, output int l, output int s);
        a = 0; l = 7; s = 0;
        for (int i = 0; i < N; i++)
            if (m_cause[i] == 1 && m_en[i] == 1 && m_lvl[i] != 7 && m_lvl[i] < l) begin
                a = 1; l = m_lvl[i]; s = i;
            end
    endfunction

    always @(posedge clk) begin
        int a, l, s;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_cause[i] = 0; m_en[i] = 0; m_lvl[i] = 7; end
            m_mask = 7; m_ack = 0; m_src = 0;
            m_stack.delete();
        end else begin
            msel(a, l, s);
            m_ack = 0;
            if (reti) begin
                if (m_stack.size() > 0) m_mask = m_stack.pop_back();
            end else if (a == 1 && l < m_mask && gie && bnd) begin
                m_stack.push_back(m_mask);
                m_mask = l; m_ack = 1; m_src = s;
            end
            for (int i = 0; i < N; i++)
                if (evt[i]) m_cause[i] = 1;
                else if (clr[i]) m_cause[i] = 0;
            if (en_wr) for (int i = 0; i < N; i++) m_en[i] = int'(en_wdata[i]);
            if (lvl_wr) m_lvl[lvl_idx] = int'(lvl_wdata);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Full comparison of the outputs against the model.
    task automatic compare();
        int a, l, s, cv;
        msel(a, l, s);
        cv = 0;
        for (int i = 0; i < N; i++) cv |= (m_cause[i] << i);
        chk(int'(cause) == cv, "R1 R7 cause", int'(cause), cv);
        chk(int'(req_any) == a, "R2 req_any", int'(req_any), a);
        if (a == 1) begin
            chk(int'(req_lvl) == l, "R3 req_lvl", int'(req_lvl), l);
            chk(int'(req_src) == s, "R3 req_src", int'(req_src), s);
        end
        chk(int'(ack) == m_ack, "R5 R6 ack", int'(ack), m_ack);
        if (m_ack == 1) chk(int'(ack_src) == m_src, "R6 ack_src", int'(ack_src), m_src);
        chk(int'(mask) == m_mask, "R4 R8 mask", int'(mask), m_mask);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        evt = '0; clr = '0; en_wr = 1'b0; lvl_wr = 1'b0;
    endtask

    task automatic set_lvl(input int idx, input int v);
        lvl_wr = 1'b1; lvl_idx = 3'(idx); lvl_wdata = 3'(v);
        step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R9 reset state
        chk(mask == 3'd7, "R9 mask", int'(mask), 7);
        chk(ack == 1'b0, "R9 ack", int'(ack), 0);
        chk(cause == 8'h00, "R9 cause", int'(cause), 0);
        chk(req_any == 1'b0, "R9 req_any", int'(req_any), 0);

        set_lvl(0, 7); set_lvl(1, 5); set_lvl(2, 3); set_lvl(5, 3);
        en_wr = 1'b1; en_wdata = 8'hFF; step();
        evt = 8'h27; step();
        chk(cause == 8'h27, "R1 set", int'(cause), 'h27);
        chk(req_lvl == 3'd3, "R3 level", int'(req_lvl), 3);
        chk(req_src == 3'd2, "R3 tie index", int'(req_src), 2);

        gie = 1'b0; bnd = 1'b1; step();
        chk(ack == 1'b0, "R5 gie low", int'(ack), 0);
        gie = 1'b1; bnd = 1'b0; step();
        chk(ack == 1'b0, "R5 no boundary", int'(ack), 0);
        bnd = 1'b1; step();
        chk(ack == 1'b1, "R6 ack", int'(ack), 1);
        chk(ack_src == 3'd2, "R6 ack_src", int'(ack_src), 2);
        chk(mask == 3'd3, "R6 mask", int'(mask), 3);
        bnd = 1'b0; step();
        chk(ack == 1'b0, "R6 single pulse", int'(ack), 0);
        chk(cause[2] == 1'b1, "R7 cause kept", int'(cause[2]), 1);
        bnd = 1'b1; step();
        chk(ack == 1'b0, "R4 equal level", int'(ack), 0);
        bnd = 1'b0;

        set_lvl(6, 1);
        evt = 8'h40; step();
        bnd = 1'b1; step();
        chk(ack_src == 3'd6 && mask == 3'd1, "R6 nested", int'(mask), 1);
        bnd = 1'b0; reti = 1'b1; step();
        chk(mask == 3'd3, "R8 first return", int'(mask), 3);
        step();
        chk(mask == 3'd7, "R8 second return", int'(mask), 7);
        step();
        chk(mask == 3'd7, "R8 empty return", int'(mask), 7);
        reti = 1'b0;

        en_wr = 1'b1; en_wdata = 8'hFB; step();
        chk(req_src == 3'd6, "R3 after disable", int'(req_src), 6);
        clr = 8'hFF; evt = 8'h04; step();
        chk(cause == 8'h04, "R1 event beats clear", int'(cause), 4);
        chk(req_any == 1'b0, "R2 enable off", int'(req_any), 0);
        clr = 8'h04; step();
        chk(cause == 8'h00, "R1 cleared", int'(cause), 0);
        evt = 8'h01; en_wr = 1'b1; en_wdata = 8'hFF; step();
        chk(req_any == 1'b0, "R2 level seven", int'(req_any), 0);

        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 6 == 0) evt = 8'(1 << ($urandom % 8));
            if ($urandom % 9 == 0) clr = 8'(1 << ($urandom % 8));
            if ($urandom % 12 == 0) begin
                lvl_wr = 1'b1; lvl_idx = 3'($urandom % 8); lvl_wdata = 3'($urandom % 8);
            end
            if ($urandom % 50 == 0) begin en_wr = 1'b1; en_wdata = 8'($urandom); end
            gie  = ($urandom % 5) != 0;
            bnd  = ($urandom % 2) != 0;
            reti = ($urandom % 8) == 0;
            step();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule